// File: doc/BRIEF.md
# Doubleword ECC Check-Byte Generator and Line Error Classifier

This block protects 64-bit doublewords with an 8-bit check byte. Each check bit is the parity of the data bits picked out by one of eight masks. All eight masks come from one 64-bit base pattern, rotated left by whole bytes. For every valid doubleword the block recomputes the check byte and XORs it with the stored check byte to form a syndrome. It then sorts the result into one of three classes: clean, single-bit or multi-bit. The class comes only from the number of set syndrome bits. The block does not locate or correct the failing bit.

One doubleword may arrive every cycle, qualified by `in_valid`, and there is no backpressure. A single register stage produces the per-doubleword result. A line tracker groups consecutive accepted doublewords into lines of four. At the end of each line it reports a bad-ECC vector with the first doubleword in the most significant bit, together with line-wide single-bit and multi-bit flags.

The tracker is a three-state machine with a slot counter:
- `LN_FIRST` waits for slot 0. A result moves it to `LN_MIDDLE`.
- `LN_MIDDLE` takes slots 1 and 2. After slot 2 it moves to `LN_LAST`.
- `LN_LAST` takes slot 3, publishes the line and returns to `LN_FIRST`.

Without a result the machine stays in its state. Reset forces `LN_FIRST`.

Top module: `ecc7264_line_checker`

## Requirements
- R1: Check bit i (0..7) is the XOR of the data bits selected by mask i. Mask 0 is 64'h0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits. Bit 7 is the MSB of `out_check`.
- R2: `out_syndrome` is the computed check byte XOR `in_check`. When it is zero, both `out_single` and `out_multi` are 0.
- R3: A syndrome with exactly one bit set gives `out_single`=1 and `out_multi`=0.
- R4: A syndrome with two or more bits set gives `out_multi`=1 and `out_single`=0.
- R5: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. Back-to-back inputs give back-to-back results.
- R6: Every four accepted doublewords form a line. The offset advances only on cycles with `in_valid` high. `line_valid` pulses for one cycle, one cycle after the result of the fourth doubleword.
- R7: The bad-ECC flag (nonzero syndrome) of the doubleword at offset k goes to `line_bad` bit 3-k. Offset 0 maps to bit 3 and offset 3 to bit 0.
- R8: `line_single` and `line_multi` are the OR of the per-doubleword flags of the current line only. Flags from earlier lines do not carry over.
- R9: Synchronous active-high reset clears all outputs and returns the line offset to 0.
- R10: `line_bad`, `line_single` and `line_multi` hold their values between `line_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Doubleword present this cycle |
| in_data | input | 64 | Data doubleword |
| in_check | input | 8 | Stored check byte |
| out_valid | output | 1 | Per-doubleword result valid |
| out_check | output | 8 | Recomputed check byte |
| out_syndrome | output | 8 | Computed XOR stored |
| out_single | output | 1 | Single-bit error class |
| out_multi | output | 1 | Multi-bit error class |
| line_valid | output | 1 | Line result pulse |
| line_bad | output | 4 | Per-offset bad-ECC vector, offset 0 in bit 3 |
| line_single | output | 1 | Some doubleword in the line had a single-bit error |
| line_multi | output | 1 | Some doubleword in the line had a multi-bit error |

## Verification
The assertions check these on every cycle:
- the one-cycle valid latency;
- that the two class flags are never high together;
- that the class agrees with the syndrome weight;
- that a line pulse always follows a result;
- that the line outputs hold between pulses;
- that reset clears the valids.

Only the bench scenarios can show the following:
- the check-byte values, which a reference mask model computes;
- the mapping of each offset to its `line_bad` bit;
- the clearing of line flags from one line to the next;
- offset counting across idle gaps and across a reset in the middle of a line.

// File: rtl/ecc7264_pkg.sv
package ecc7264_pkg;

    parameter int unsigned DW_W   = 64;
    parameter int unsigned CK_W   = 8;
    parameter int unsigned ROT_W  = DW_W / CK_W;
    parameter logic [DW_W-1:0] DEFAULT_BASE_MASK = 64'h0738C808099264FF;

    typedef enum logic [1:0] {
        LN_FIRST  = 2'd0,
        LN_MIDDLE = 2'd1,
        LN_LAST   = 2'd2
    } line_state_e;

    // Rotate the base pattern left by k whole bytes.
    function automatic logic [DW_W-1:0] rot_mask(input logic [DW_W-1:0] base,
                                                 input int unsigned k);
        logic [DW_W-1:0] m;
        m = base;
        for (int unsigned r = 0; r < k; r++) begin
            m = {m[DW_W-ROT_W-1:0], m[DW_W-1:DW_W-ROT_W]};
        end
        return m;
    endfunction

    function automatic int unsigned ones_in(input logic [CK_W-1:0] v);
        int unsigned n;
        n = 0;
        for (int unsigned b = 0; b < CK_W; b++) begin
            n = n + int'(v[b]);
        end
        return n;
    endfunction

endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen
    import ecc7264_pkg::*;
#(
    parameter logic [DW_W-1:0] BASE_MASK = DEFAULT_BASE_MASK
) (
    input  logic [DW_W-1:0] data,
    output logic [CK_W-1:0] chk
);

    for (genvar gi = 0; gi < CK_W; gi++) begin : g_bit
        localparam logic [DW_W-1:0] MASK_I = rot_mask(BASE_MASK, gi);
        assign chk[gi] = ^(data & MASK_I);
    end

endmodule

// File: rtl/ecc_syn_class.sv
module ecc_syn_class
    import ecc7264_pkg::*;
(
    input  logic [CK_W-1:0] syn,
    output logic            is_single,
    output logic            is_multi
);

    int unsigned weight;

    always_comb begin
        weight    = ones_in(syn);
        is_single = (weight == 1);
        is_multi  = (weight > 1);
    end

endmodule

// File: rtl/ecc_dw_stage.sv
module ecc_dw_stage
    import ecc7264_pkg::*;
#(
    parameter logic [DW_W-1:0] BASE_MASK = DEFAULT_BASE_MASK
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [DW_W-1:0] in_data,
    input  logic [CK_W-1:0] in_check,
    output logic            res_valid,
    output logic [CK_W-1:0] res_check,
    output logic [CK_W-1:0] res_syn,
    output logic            res_single,
    output logic            res_multi
);

    logic [CK_W-1:0] calc_chk;
    logic [CK_W-1:0] calc_syn;
    logic            calc_single;
    logic            calc_multi;

    ecc_chk_gen #(.BASE_MASK(BASE_MASK)) u_gen (
        .data (in_data),
        .chk  (calc_chk)
    );

    assign calc_syn = calc_chk ^ in_check;

    ecc_syn_class u_class (
        .syn       (calc_syn),
        .is_single (calc_single),
        .is_multi  (calc_multi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_check  <= '0;
            res_syn    <= '0;
            res_single <= 1'b0;
            res_multi  <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_check  <= calc_chk;
                res_syn    <= calc_syn;
                res_single <= calc_single;
                res_multi  <= calc_multi;
            end
        end
    end

endmodule

// File: rtl/ecc_line_fsm.sv
module ecc_line_fsm
    import ecc7264_pkg::*;
#(
    parameter int unsigned LINE_DW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dw_valid,
    input  logic               dw_single,
    input  logic               dw_multi,
    output logic               line_valid,
    output logic [LINE_DW-1:0] line_bad,
    output logic               line_single,
    output logic               line_multi
);

    localparam int unsigned SLOT_W = (LINE_DW > 1) ? $clog2(LINE_DW) : 1;
    localparam logic [SLOT_W-1:0] SLOT_PRE_LAST = SLOT_W'(LINE_DW - 2);

    line_state_e        state_q, state_nx;
    logic [SLOT_W-1:0]  slot_q, slot_nx;
    logic [LINE_DW-1:0] flag_vec;
    logic [LINE_DW-1:0] acc_bad;
    logic               acc_single;
    logic               acc_multi;
    logic               dw_bad;

    assign dw_bad = dw_single | dw_multi;

    always_comb begin
        for (int k = 0; k < int'(LINE_DW); k++) begin
            flag_vec[k] = dw_bad && (slot_q == SLOT_W'(int'(LINE_DW) - 1 - k));
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_FIRST;
            slot_q  <= '0;
        end else begin
            state_q <= state_nx;
            slot_q  <= slot_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        slot_nx  = slot_q;
        unique case (state_q)
            LN_FIRST: begin
                if (dw_valid) begin
                    slot_nx  = SLOT_W'(1);
                    state_nx = (LINE_DW == 2) ? LN_LAST : LN_MIDDLE;
                end
            end
            LN_MIDDLE: begin
                if (dw_valid) begin
                    slot_nx = slot_q + SLOT_W'(1);
                    if (slot_q == SLOT_PRE_LAST) begin
                        state_nx = LN_LAST;
                    end
                end
            end
            LN_LAST: begin
                if (dw_valid) begin
                    slot_nx  = '0;
                    state_nx = LN_FIRST;
                end
            end
            default: begin
                slot_nx  = '0;
                state_nx = LN_FIRST;
            end
        endcase
    end

    // Outputs and accumulation
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_bad     <= '0;
            acc_single  <= 1'b0;
            acc_multi   <= 1'b0;
            line_valid  <= 1'b0;
            line_bad    <= '0;
            line_single <= 1'b0;
            line_multi  <= 1'b0;
        end else begin
            line_valid <= 1'b0;
            if (dw_valid) begin
                unique case (state_q)
                    LN_FIRST: begin
                        acc_bad    <= flag_vec;
                        acc_single <= dw_single;
                        acc_multi  <= dw_multi;
                    end
                    LN_MIDDLE: begin
                        acc_bad    <= acc_bad | flag_vec;
                        acc_single <= acc_single | dw_single;
                        acc_multi  <= acc_multi | dw_multi;
                    end
                    LN_LAST: begin
                        line_valid  <= 1'b1;
                        line_bad    <= acc_bad | flag_vec;
                        line_single <= acc_single | dw_single;
                        line_multi  <= acc_multi | dw_multi;
                    end
                    default: begin
                        acc_bad <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ecc7264_line_checker.sv
module ecc7264_line_checker
    import ecc7264_pkg::*;
#(
    parameter logic [63:0] BASE_MASK = 64'h0738C808099264FF,
    parameter int unsigned LINE_DW   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [63:0]        in_data,
    input  logic [7:0]         in_check,
    output logic               out_valid,
    output logic [7:0]         out_check,
    output logic [7:0]         out_syndrome,
    output logic               out_single,
    output logic               out_multi,
    output logic               line_valid,
    output logic [LINE_DW-1:0] line_bad,
    output logic               line_single,
    output logic               line_multi
);

    ecc_dw_stage #(.BASE_MASK(BASE_MASK)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_check   (in_check),
        .res_valid  (out_valid),
        .res_check  (out_check),
        .res_syn    (out_syndrome),
        .res_single (out_single),
        .res_multi  (out_multi)
    );

    ecc_line_fsm #(.LINE_DW(LINE_DW)) u_line (
        .clk         (clk),
        .rst         (rst),
        .dw_valid    (out_valid),
        .dw_single   (out_single),
        .dw_multi    (out_multi),
        .line_valid  (line_valid),
        .line_bad    (line_bad),
        .line_single (line_single),
        .line_multi  (line_multi)
    );

endmodule

// File: rtl/ecc7264_line_checker_sva.sv
module ecc7264_line_checker_sva #(
    parameter int unsigned LINE_DW = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               out_valid,
    input logic [7:0]         out_syndrome,
    input logic               out_single,
    input logic               out_multi,
    input logic               line_valid,
    input logic [LINE_DW-1:0] line_bad,
    input logic               line_single,
    input logic               line_multi
);

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_zero_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_syndrome == 8'h00) |-> (!out_single && !out_multi));

    a_r3_single_weight: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $countones(out_syndrome) == 1) |-> (out_single && !out_multi));

    a_r4_multi_weight: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $countones(out_syndrome) > 1) |-> (out_multi && !out_single));

    a_r6_line_after_result: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> $past(out_valid));

    a_r10_hold_bad: assert property (@(posedge clk) disable iff (rst)
        !line_valid |-> ($stable(line_bad) && $stable(line_single) && $stable(line_multi)));

    a_r8_clean_line_flags: assert property (@(posedge clk) disable iff (rst)
        (line_valid && line_bad == '0) |-> (!line_single && !line_multi));

    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !line_valid));

endmodule

bind ecc7264_line_checker ecc7264_line_checker_sva #(.LINE_DW(LINE_DW)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_syndrome (out_syndrome),
    .out_single   (out_single),
    .out_multi    (out_multi),
    .line_valid   (line_valid),
    .line_bad     (line_bad),
    .line_single  (line_single),
    .line_multi   (line_multi)
);

// File: tb/tb_ecc7264_line_checker.sv
`timescale 1ns/1ps
module tb_ecc7264_line_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_check = '0;
    logic        out_valid, out_single, out_multi;
    logic [7:0]  out_check, out_syndrome;
    logic        line_valid, line_single, line_multi;
    logic [3:0]  line_bad;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ecc7264_line_checker dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_check(in_check), .out_valid(out_valid), .out_check(out_check),
        .out_syndrome(out_syndrome), .out_single(out_single), .out_multi(out_multi),
        .line_valid(line_valid), .line_bad(line_bad),
        .line_single(line_single), .line_multi(line_multi)
    );

    // Scoreboard queues
    logic [7:0]  q_chk[$];
    logic [7:0]  q_syn[$];
    logic [5:0]  q_line[$];   // {bad[3:0], single, multi}
    int          slot = 0;
    logic [3:0]  acc_bad;
    logic        acc_s, acc_m;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mask(input int i);
        logic [63:0] m = 64'h0738C808099264FF;
        for (int r = 0; r < i; r++) m = {m[55:0], m[63:56]};
        return m;
    endfunction

    function automatic logic [7:0] ref_check(input logic [63:0] d);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = ^(d & ref_mask(i));
        return c;
    endfunction

    // Driver: push expected results, drive one doubleword
    task automatic send(input logic [63:0] d, input logic [7:0] stored);
        logic [7:0] c, s;
        int w;
        c = ref_check(d);
        s = c ^ stored;
        w = $countones(s);
        q_chk.push_back(c);
        q_syn.push_back(s);
        if (slot == 0) begin
            acc_bad = '0; acc_s = 0; acc_m = 0;
        end
        acc_bad[3 - slot] = (s != 0);
        acc_s = acc_s | (w == 1);
        acc_m = acc_m | (w > 1);
        if (slot == 3) begin
            q_line.push_back({acc_bad, acc_s, acc_m});
            slot = 0;
        end else slot++;
        in_valid = 1'b1; in_data = d; in_check = stored;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while ((q_chk.size() != 0 || q_line.size() != 0) && guard < 50) begin
            @(negedge clk); guard++;
        end
        idle(3);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_chk.size() == 0) begin
                    check(0, "R5 unexpected out_valid", 1, 0);
                end else begin
                    logic [7:0] ec, es;
                    int w;
                    ec = q_chk.pop_front();
                    es = q_syn.pop_front();
                    w = $countones(es);
                    check(out_check == ec, "R1 check byte", out_check, ec);
                    check(out_syndrome == es, "R2 syndrome", out_syndrome, es);
                    check(out_single == (w == 1), "R3 single class", out_single, w == 1);
                    check(out_multi == (w > 1), "R4 multi class", out_multi, w > 1);
                end
            end
            if (line_valid) begin
                if (q_line.size() == 0) begin
                    check(0, "R6 unexpected line_valid", 1, 0);
                end else begin
                    logic [5:0] el;
                    el = q_line.pop_front();
                    check(line_bad == el[5:2], "R7 line_bad", line_bad, el[5:2]);
                    check({line_single, line_multi} == el[1:0], "R8 line flags",
                          {line_single, line_multi}, el[1:0]);
                end
            end else if (q_line.size() == 0 && !out_valid) begin
                // R10: values hold while no pulse
            end
        end
    end

    initial begin
        logic [63:0] d;
        logic [3:0] held_bad;
        logic [1:0] held_fl;
        repeat (3) @(negedge clk);
        // R9 reset state
        check({out_valid, out_check, out_syndrome, out_single, out_multi} == '0,
              "R9 reset dw outputs", out_check, 0);
        check({line_valid, line_bad, line_single, line_multi} == '0,
              "R9 reset line outputs", line_bad, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1/R2: zero data, correct check; all-ones data; walking patterns
        send(64'h0, 8'h00);
        send(64'hFFFF_FFFF_FFFF_FFFF, ref_check(64'hFFFF_FFFF_FFFF_FFFF));
        send(64'h0123_4567_89AB_CDEF, ref_check(64'h0123_4567_89AB_CDEF));
        send(64'h8000_0000_0000_0001, ref_check(64'h8000_0000_0000_0001));
        // R3: single check-bit flip at offset 0 -> line_bad bit 3 (R7)
        send(64'hDEAD_BEEF_CAFE_F00D, ref_check(64'hDEAD_BEEF_CAFE_F00D) ^ 8'h01);
        send(64'h1, ref_check(64'h1));
        send(64'h2, ref_check(64'h2));
        // R4: double flip at offset 3 -> bit 0
        send(64'h3, ref_check(64'h3) ^ 8'h81);
        // R8: clean line after error line, flags must clear
        for (int i = 0; i < 4; i++) send(64'h1111 * (i + 1), ref_check(64'h1111 * (i + 1)));
        // Data bit flips: class follows syndrome weight
        for (int b = 0; b < 8; b++) begin
            d = 64'h5A5A_A5A5_0F0F_F0F0;
            send(d ^ (64'h1 << (b * 9)), ref_check(d));
        end
        drain();

        // R10: line outputs hold between pulses
        send(64'h0, 8'hFF);
        send(64'h0, 8'h00);
        send(64'h0, 8'h00);
        send(64'h0, 8'h10);
        idle(2);
        held_bad = line_bad; held_fl = {line_single, line_multi};
        send(64'h0, 8'h00);
        send(64'h0, 8'h00);
        idle(4);
        check(line_bad == held_bad && {line_single, line_multi} == held_fl,
              "R10 line hold", line_bad, held_bad);
        // R6: gaps between valids, offset advances only on valid
        send(64'h0, 8'h00);
        idle(3);
        send(64'h7, ref_check(64'h7) ^ 8'h40);   // offset 3 of this line
        drain();

        // R5: back-to-back four-line burst
        for (int i = 0; i < 16; i++) begin
            d = {32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 ^ i};
            send(d, ref_check(d) ^ ((i % 5 == 0) ? 8'h20 : ((i % 7 == 1) ? 8'h0C : 8'h00)));
        end
        drain();

        // R9: reset mid-line returns offset to 0
        send(64'h0, 8'h00);
        send(64'h0, 8'h00);
        idle(2);
        q_chk.delete(); q_syn.delete();
        rst = 1'b1;
        slot = 0;
        @(negedge clk);
        @(negedge clk);
        check({out_valid, line_valid, line_bad} == '0, "R9 mid-line reset", line_bad, 0);
        rst = 1'b0;
        send(64'h0, 8'h02);      // new offset 0 -> bit 3
        send(64'h0, 8'h00);
        send(64'h0, 8'h00);
        send(64'h0, 8'h00);
        drain();
        check(q_line.size() == 0, "R6 all lines seen", q_line.size(), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule